// File: doc/BRIEF.md
# Operand-Gathering Issue Manager

This block is the bookkeeping stage that sits in front of a single functional unit. It accepts one operation on a dispatch pulse and then owns it until the result has been written back. It stays in flight for the whole of that time, so the scheduling logic around it always knows whether the unit is occupied.

Once dispatched, the block asks for each source operand that is really needed through a per-port request/grant pair. A port can be dropped from reading in three ways: it can be forced to zero (port A), replaced by an immediate (port B), or masked. The block then hands the operation and all of its operands to the functional unit over a valid/ready handshake, and waits for the unit to report a result. Finally it raises a write-back request and releases the operation when the write-back grant arrives.

The number of source ports (two or three) and the data and opcode widths are parameters. A third port is read like the others but has no substitution rule.

Top module: `cu_issue_mgr`

## Requirements
- R1: After reset, `inflight_o`, every bit of `rd_req_o`, `wb_req_o` and `fu_valid_o` are low. `inflight_o` rises only in the cycle after a cycle with `dispatch_i` high. While idle, grant pulses on `rd_grant_i` or `wb_grant_i` change none of these outputs.
- R2: The opcode, negate-A flag, immediate, immediate-valid flag, force-zero-A flag and `skip_mask_i` are captured in the dispatch cycle. Changing those inputs afterwards does not alter the opcode sent on `fu_op_o` or the operands and result of the operation.
- R3: Every port that must be read raises its `rd_req_o` bit in the first cycle after dispatch. The bit stays high for any number of cycles until its `rd_grant_i` bit is high.
- R4: A grant may arrive in the first cycle its request is visible. While a port's request and grant are both high, that port's slice `rf_data_i[k*DATA_W +: DATA_W]` appears unchanged on `fu_opnd_o[k*DATA_W +: DATA_W]` in the same cycle.
- R5: A request bit falls in the cycle after its grant was high. It does not rise again before `inflight_o` has fallen.
- R6: Port 0 (A) is not requested when force-zero-A is set and is forwarded as zero. Port 1 (B) is not requested when immediate-valid is set and is forwarded as `imm_i`. A port whose `skip_mask_i` bit is set is never requested and is forwarded as zero unless its substitution rule applies, which takes precedence.
- R7: Once no request is pending, `fu_valid_o` is raised and held with stable operands until `fu_ready_i`. Exactly one handshake is made per operation, and `fu_neg_a_o` carries the captured negate-A flag.
- R8: `wb_req_o` rises after the unit reports `fu_res_valid_i` and stays high until `wb_grant_i`. While the grant is high, `wb_data_o` holds the unit's result.
- R9: `inflight_o` stays high from dispatch until the write-back grant, and then falls together with `wb_req_o` in the next cycle. With the unit stalling up to two cycles at each handshake, an operation takes fewer than 50 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dispatch_i | input | 1 | One-cycle pulse that hands over an operation |
| op_type_i | input | OP_W | Operation code |
| neg_a_i | input | 1 | Ask the unit to invert operand A |
| imm_i | input | DATA_W | Immediate value for port B |
| imm_vld_i | input | 1 | Use the immediate instead of reading port B |
| force_zero_a_i | input | 1 | Use zero instead of reading port A |
| skip_mask_i | input | NUM_SRC | Ports never to be requested |
| inflight_o | output | 1 | An operation is held |
| rd_req_o | output | NUM_SRC | Per-port operand read request |
| rd_grant_i | input | NUM_SRC | Per-port operand read grant |
| rf_data_i | input | NUM_SRC*DATA_W | Operand values, port k in slice k |
| fu_valid_o | output | 1 | Operation offered to the unit |
| fu_ready_i | input | 1 | Unit accepts the operation |
| fu_op_o | output | OP_W | Captured opcode |
| fu_neg_a_o | output | 1 | Captured negate-A flag |
| fu_opnd_o | output | NUM_SRC*DATA_W | Operands, port k in slice k |
| fu_res_valid_i | input | 1 | Unit presents its result |
| fu_res_ready_o | output | 1 | Block waits for the result |
| fu_res_i | input | DATA_W | Result from the unit |
| wb_req_o | output | 1 | Write-back request |
| wb_grant_i | input | 1 | Write-back grant |
| wb_data_o | output | DATA_W | Result to be written back |

## Verification
The sweep covers every combination of force-zero, immediate-valid and the two mask bits. A design that let a substitution lose to the mask, or that requested a substituted port, would forward the wrong operand and produce a wrong result, or keep a request hanging. Grants are given in the very cycle a request appears as well as after stalls. This catches a request that drops early, a pass-through that works only on the following cycle, or a request that comes back after its grant. The inputs are scrambled right after dispatch, so a block that reads live inputs instead of its captured copy hands the unit the wrong opcode or operands. Write-back is delayed by a cycle in half the runs, which exposes an in-flight flag that falls before the grant.

// File: rtl/cu_issue_pkg.sv
package cu_issue_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_GATHER   = 3'd1,
      ST_OFFER    = 3'd2,
      ST_AWAIT    = 3'd3,
      ST_WRITE    = 3'd4
   } cu_state_e;

   localparam int MIN_SRC = 2;
   localparam int MAX_SRC = 3;

endpackage

// File: rtl/cu_opnd_slot.sv
module cu_opnd_slot #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              mask_i,
   input  logic              subst_i,
   input  logic [DATA_W-1:0] subst_val_i,
   input  logic              grant_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              req_o,
   output logic [DATA_W-1:0] opnd_o
);

   logic              pend_q;
   logic [DATA_W-1:0] held_q;
   logic              hit;

   assign hit = grant_i & pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         held_q <= '0;
      end else if (take_i) begin
         pend_q <= ~mask_i & ~subst_i;
         held_q <= subst_i ? subst_val_i : '0;
      end else if (hit) begin
         pend_q <= 1'b0;
         held_q <= data_i;
      end
   end

   assign req_o  = pend_q;
   assign opnd_o = hit ? data_i : held_q;

endmodule

// File: rtl/cu_seq.sv
module cu_seq
   import cu_issue_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      take_i,
   input  logic      reads_done_i,
   input  logic      fu_ready_i,
   input  logic      res_valid_i,
   input  logic      wb_grant_i,
   output cu_state_e state_o
);

   cu_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (take_i)       st_d = ST_GATHER;
         ST_GATHER: if (reads_done_i) st_d = ST_OFFER;
         ST_OFFER:  if (fu_ready_i)   st_d = ST_AWAIT;
         ST_AWAIT:  if (res_valid_i)  st_d = ST_WRITE;
         ST_WRITE:  if (wb_grant_i)   st_d = ST_IDLE;
         default:                     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

endmodule

// File: rtl/cu_issue_mgr.sv
module cu_issue_mgr
   import cu_issue_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int OP_W    = 4,
   parameter int NUM_SRC = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dispatch_i,
   input  logic [OP_W-1:0]           op_type_i,
   input  logic                      neg_a_i,
   input  logic [DATA_W-1:0]         imm_i,
   input  logic                      imm_vld_i,
   input  logic                      force_zero_a_i,
   input  logic [NUM_SRC-1:0]        skip_mask_i,
   output logic                      inflight_o,
   output logic [NUM_SRC-1:0]        rd_req_o,
   input  logic [NUM_SRC-1:0]        rd_grant_i,
   input  logic [NUM_SRC*DATA_W-1:0] rf_data_i,
   output logic                      fu_valid_o,
   input  logic                      fu_ready_i,
   output logic [OP_W-1:0]           fu_op_o,
   output logic                      fu_neg_a_o,
   output logic [NUM_SRC*DATA_W-1:0] fu_opnd_o,
   input  logic                      fu_res_valid_i,
   output logic                      fu_res_ready_o,
   input  logic [DATA_W-1:0]         fu_res_i,
   output logic                      wb_req_o,
   input  logic                      wb_grant_i,
   output logic [DATA_W-1:0]         wb_data_o
);

   localparam int BUS_W = NUM_SRC * DATA_W;

   if (NUM_SRC < MIN_SRC || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("cu_issue_mgr: NUM_SRC must be 2 or 3");
   end
   if (DATA_W < 1 || OP_W < 1) begin : g_bad_width
      $error("cu_issue_mgr: widths must be positive");
   end

   cu_state_e          state;
   logic               take;
   logic [OP_W-1:0]    op_q;
   logic               neg_q;
   logic [DATA_W-1:0]  res_q;
   logic [NUM_SRC-1:0] subst;
   logic [BUS_W-1:0]   subst_val;

   assign take = dispatch_i & (state == ST_IDLE);

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_port
      if (k == 0) begin : g_zero
         assign subst[k]                         = force_zero_a_i;
         assign subst_val[k*DATA_W +: DATA_W]    = '0;
      end else if (k == 1) begin : g_imm
         assign subst[k]                         = imm_vld_i;
         assign subst_val[k*DATA_W +: DATA_W]    = imm_i;
      end else begin : g_plain
         assign subst[k]                         = 1'b0;
         assign subst_val[k*DATA_W +: DATA_W]    = '0;
      end

      cu_opnd_slot #(.DATA_W(DATA_W)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .take_i      (take),
         .mask_i      (skip_mask_i[k]),
         .subst_i     (subst[k]),
         .subst_val_i (subst_val[k*DATA_W +: DATA_W]),
         .grant_i     (rd_grant_i[k]),
         .data_i      (rf_data_i[k*DATA_W +: DATA_W]),
         .req_o       (rd_req_o[k]),
         .opnd_o      (fu_opnd_o[k*DATA_W +: DATA_W])
      );
   end

   cu_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .reads_done_i (~|rd_req_o),
      .fu_ready_i   (fu_ready_i),
      .res_valid_i  (fu_res_valid_i),
      .wb_grant_i   (wb_grant_i),
      .state_o      (state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= '0;
         neg_q <= 1'b0;
         res_q <= '0;
      end else begin
         if (take) begin
            op_q  <= op_type_i;
            neg_q <= neg_a_i;
         end
         if (state == ST_AWAIT && fu_res_valid_i) res_q <= fu_res_i;
      end
   end

   assign inflight_o     = (state != ST_IDLE);
   assign fu_valid_o     = (state == ST_OFFER);
   assign fu_res_ready_o = (state == ST_AWAIT);
   assign wb_req_o       = (state == ST_WRITE);
   assign fu_op_o        = op_q;
   assign fu_neg_a_o     = neg_q;
   assign wb_data_o      = res_q;

endmodule

// File: rtl/cu_issue_chk.sv
module cu_issue_chk #(
   parameter int DATA_W  = 16,
   parameter int NUM_SRC = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      dispatch_i,
   input logic                      inflight_o,
   input logic [NUM_SRC-1:0]        rd_req_o,
   input logic [NUM_SRC-1:0]        rd_grant_i,
   input logic                      fu_valid_o,
   input logic                      fu_ready_i,
   input logic [NUM_SRC*DATA_W-1:0] fu_opnd_o,
   input logic                      wb_req_o,
   input logic                      wb_grant_i
);

   a_r1_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inflight_o) |-> $past(dispatch_i));

   a_r3_req_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_req_o) |-> inflight_o);

   a_r7_no_offer_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
      fu_valid_o |-> (rd_req_o == '0));

   a_r7_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_valid_o && !fu_ready_i) |=> (fu_valid_o && $stable(fu_opnd_o)));

   a_r8_wb_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req_o |-> inflight_o);

   a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inflight_o) |-> $past(wb_grant_i && wb_req_o));

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_port_chk
      a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req_o[k] && !rd_grant_i[k]) |=> rd_req_o[k]);

      a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req_o[k] && rd_grant_i[k]) |=> !rd_req_o[k]);

      a_r5_req_only_after_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rd_req_o[k]) |-> ($past(dispatch_i) && !$past(inflight_o)));
   end

endmodule

bind cu_issue_mgr cu_issue_chk #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dispatch_i (dispatch_i),
   .inflight_o (inflight_o),
   .rd_req_o   (rd_req_o),
   .rd_grant_i (rd_grant_i),
   .fu_valid_o (fu_valid_o),
   .fu_ready_i (fu_ready_i),
   .fu_opnd_o  (fu_opnd_o),
   .wb_req_o   (wb_req_o),
   .wb_grant_i (wb_grant_i)
);

// File: tb/sim_cu_issue_mgr.sv
module sim_cu_issue_mgr;

   localparam int W   = 16;
   localparam int OPW = 4;
   localparam int NS  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            dispatch_i = 0;
   logic [OPW-1:0]  op_type_i = '0;
   logic            neg_a_i = 0;
   logic [W-1:0]    imm_i = '0;
   logic            imm_vld_i = 0;
   logic            force_zero_a_i = 0;
   logic [NS-1:0]   skip_mask_i = '0;
   logic            inflight_o;
   logic [NS-1:0]   rd_req_o;
   logic [NS-1:0]   rd_grant_i = '0;
   logic [NS*W-1:0] rf_data_i = '0;
   logic            fu_valid_o;
   logic            fu_ready_i = 0;
   logic [OPW-1:0]  fu_op_o;
   logic            fu_neg_a_o;
   logic [NS*W-1:0] fu_opnd_o;
   logic            fu_res_valid_i = 0;
   logic            fu_res_ready_o;
   logic [W-1:0]    fu_res_i = '0;
   logic            wb_req_o;
   logic            wb_grant_i = 0;
   logic [W-1:0]    wb_data_o;

   cu_issue_mgr #(.DATA_W(W), .OP_W(OPW), .NUM_SRC(NS)) u0 (.*);

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] fu_fn(input logic [OPW-1:0] op, input logic neg,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] x;
      x = neg ? ~a : a;
      case (op[1:0])
         2'd0:    return x + b;
         2'd1:    return x - b;
         2'd2:    return x ^ b;
         default: return x;
      endcase
   endfunction

   // functional-unit model, driven away from the active edge
   int             fu_stall_cfg = 0;
   int             fu_lat_cfg = 0;
   int             fu_mode = 0;
   int             fu_cnt = 0;
   int             fu_hs = 0;
   logic [W-1:0]   cap_a = '0, cap_b = '0;
   logic [OPW-1:0] cap_op = '0;
   logic           cap_neg = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         fu_ready_i = 0; fu_res_valid_i = 0; fu_mode = 0; fu_cnt = 0;
      end else begin
         case (fu_mode)
            0: if (fu_valid_o) begin
                  if (fu_cnt < fu_stall_cfg) begin
                     fu_cnt++; fu_ready_i = 0;
                  end else begin
                     fu_ready_i = 1;
                     cap_a = fu_opnd_o[0 +: W];
                     cap_b = fu_opnd_o[W +: W];
                     cap_op = fu_op_o;
                     cap_neg = fu_neg_a_o;
                     fu_hs++;
                     fu_mode = 1;
                  end
               end
            1: begin fu_ready_i = 0; fu_cnt = 0; fu_mode = 2; end
            2: if (fu_cnt < fu_lat_cfg) fu_cnt++;
               else begin
                  fu_res_i = fu_fn(cap_op, cap_neg, cap_a, cap_b);
                  fu_res_valid_i = 1; fu_mode = 3;
               end
            default: begin fu_res_valid_i = 0; fu_res_i = '0; fu_cnt = 0; fu_mode = 0; end
         endcase
      end
   end

   task automatic idle_noise(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_grant_i = NS'(i + 1);
         wb_grant_i = 1;
         rf_data_i = {NS{16'hDEAD}};
         #1;
         chk(!inflight_o && rd_req_o == '0 && !wb_req_o && !fu_valid_o, "R1 idle grants ignored",
             {inflight_o, rd_req_o, wb_req_o, fu_valid_o}, 0);
      end
      @(negedge clk);
      rd_grant_i = '0; wb_grant_i = 0;
   endtask

   task automatic run_op(input logic [OPW-1:0] op, input bit neg, input bit za, input bit iv,
                         input logic [W-1:0] imm, input logic [1:0] mask,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input int da, input int db, input int stall, input int lat, input int wd);
      logic [W-1:0] ea, eb, er;
      bit   pend [2];
      bit   go   [2];
      int   dly  [2];
      logic [W-1:0] val [2];
      int   t;
      ea = za ? '0 : (mask[0] ? '0 : a);
      eb = iv ? imm : (mask[1] ? '0 : b);
      er = fu_fn(op, neg, ea, eb);
      pend[0] = !za && !mask[0];
      pend[1] = !iv && !mask[1];
      dly[0] = da; dly[1] = db;
      val[0] = a;  val[1] = b;
      fu_stall_cfg = stall; fu_lat_cfg = lat; fu_hs = 0;

      @(negedge clk);
      chk(!inflight_o, "R1 idle before dispatch", inflight_o, 0);
      op_type_i = op; neg_a_i = neg; imm_i = imm; imm_vld_i = iv;
      force_zero_a_i = za; skip_mask_i = mask; dispatch_i = 1;
      @(negedge clk);
      // R2: scramble every captured input right after the dispatch edge
      dispatch_i = 0; op_type_i = ~op; neg_a_i = ~neg; imm_i = ~imm;
      imm_vld_i = ~iv; force_zero_a_i = ~za; skip_mask_i = ~mask;
      chk(inflight_o, "R1 in flight after dispatch", inflight_o, 1);
      t = 0;
      while (!wb_req_o && t < 60) begin
         for (int k = 0; k < 2; k++) begin
            chk(rd_req_o[k] == pend[k], pend[k] ? "R3 request high" : "R5/R6 request low",
                rd_req_o[k], pend[k]);
            go[k] = pend[k] && (t >= dly[k]);
            rd_grant_i[k] = go[k];
            rf_data_i[k*W +: W] = go[k] ? val[k] : ~val[k];
         end
         #1;
         for (int k = 0; k < 2; k++)
            if (go[k]) chk(fu_opnd_o[k*W +: W] == val[k], "R4 pass-through", fu_opnd_o[k*W +: W], val[k]);
         chk(inflight_o, "R9 held while working", inflight_o, 1);
         @(negedge clk);
         for (int k = 0; k < 2; k++) if (go[k]) pend[k] = 0;
         t++;
      end
      rd_grant_i = '0;
      chk(t < 50, "R9 latency", t, 50);
      chk(cap_a == ea, "R6 operand A", cap_a, ea);
      chk(cap_b == eb, "R6 operand B", cap_b, eb);
      chk(cap_op == op, "R2 captured opcode", cap_op, op);
      chk(cap_neg == neg, "R7 negate flag", cap_neg, neg);
      chk(fu_hs == 1, "R7 single handshake", fu_hs, 1);
      for (int i = 0; i < wd; i++) begin
         chk(wb_req_o && inflight_o, "R8 request held", {wb_req_o, inflight_o}, 3);
         @(negedge clk);
      end
      wb_grant_i = 1;
      #1;
      chk(wb_data_o == er, "R8 result", wb_data_o, er);
      @(negedge clk);
      wb_grant_i = 0;
      chk(!inflight_o && !wb_req_o, "R9 release", {inflight_o, wb_req_o}, 0);
      chk(rd_req_o == '0, "R5 no re-request", rd_req_o, 0);
   endtask

   bit wd_hit = 0;
   initial begin
      #(10 * 150000);
      wd_hit = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int i;
      repeat (3) @(negedge clk);
      #1;
      chk(!inflight_o && rd_req_o == '0 && !wb_req_o && !fu_valid_o, "R1 reset state",
          {inflight_o, rd_req_o, wb_req_o, fu_valid_o}, 0);
      rst_n = 1;
      idle_noise(3);
      i = 0;
      for (int za = 0; za < 2; za++)
         for (int iv = 0; iv < 2; iv++)
            for (int m = 0; m < 4; m++)
               for (int op = 0; op < 4; op++) begin
                  run_op(OPW'(op), bit'(i[0] ^ op[1]), bit'(za), bit'(iv),
                         W'(16'h8000 | (i * 5)), 2'(m),
                         W'(16'h1234 + i * 37), W'(16'h0F0F ^ (i * 91)),
                         i % 3, (i / 3) % 4, i % 3, (i / 2) % 3, i % 2);
                  if (i % 8 == 0) idle_noise(2);
                  i++;
               end
      if (!wd_hit) begin
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule